// File: doc/BRIEF.md
# Receive Output Parity Generator

This block produces one odd-parity bit for every received character that reaches the receive output register. Parity is built in two halves. The first half is a plain odd-parity bit over the decoded byte. It is formed as soon as the byte leaves the decoder, and it is written into the elasticity FIFO next to that byte. The second half runs after the FIFO read, once the status bits for that character are known. It folds the selected status bits into the stored bit and loads data, status and parity into the output register together.

A two-bit code models a three-level mode pin:

| Code | Mode | Parity coverage |
|------|------|-----------------|
| 00 or 01 | Off | No parity; the parity driver is disabled |
| 10 | Middle | The byte alone when the decoder is active; the byte plus status bits [1:0] when the decoder is bypassed |
| 11 | Full | The byte plus all three status bits |

The decoder, the FIFO storage and the status source sit outside this block.

Top module: `rx_out_parity`

## Requirements
- R1: Mode code 00 or 01 turns parity off. After the next clock edge `out_par_oe` is 0 and `out_par` is 0. Codes 10 and 11 set `out_par_oe` to 1 after the next edge.
- R2: `dec_par` is, without any clock delay, the odd parity of `dec_data`. That is, `dec_data` together with `dec_par` holds an odd number of ones.
- R3: With code 10 and `dec_en`=1, a loaded `out_par` makes `out_data` plus `out_par` odd.
- R4: With code 10 and `dec_en`=0, a loaded `out_par` makes `out_data`, `out_stat[1:0]` and `out_par` odd together.
- R5: With code 11, a loaded `out_par` makes `out_data`, `out_stat[2:0]` and `out_par` odd together.
- R6: When `dec_en`=0, `bist_en`=0 and `rd_framing`=0, the loaded `out_stat[2]` is 0. In every other case `out_stat` equals `rd_stat`.
- R7: The second stage takes the byte's parity only from the carried bit `rd_par`. If `rd_par` is inverted, the loaded `out_par` is inverted, in every mode that drives parity.
- R8: The output register loads `rd_data`, the adjusted status and parity on the edge where `rd_valid`=1. With `rd_valid`=0 it keeps its contents.
- R9: During reset `out_data`, `out_stat`, `out_par` and `out_par_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output register clock |
| rst_n | input | 1 | Active-low reset |
| mode_code | input | 2 | Parity mode: 00/01 off, 10 middle, 11 full |
| dec_en | input | 1 | 1 when the decoder is active, 0 when it is bypassed |
| bist_en | input | 1 | Receive self-test active |
| dec_data | input | DATA_W | Decoded byte on its way into the FIFO |
| dec_par | output | 1 | First-stage odd parity of `dec_data` |
| rd_valid | input | 1 | A FIFO read character is ready to load |
| rd_data | input | DATA_W | Byte read from the FIFO |
| rd_par | input | 1 | Parity bit read from the FIFO with the byte |
| rd_stat | input | STAT_W | Status bits for the character read |
| rd_framing | input | 1 | The character read is a framing character |
| out_data | output | DATA_W | Registered data |
| out_stat | output | STAT_W | Registered status |
| out_par | output | 1 | Registered parity, 0 while disabled |
| out_par_oe | output | 1 | Parity driver enable |

## Verification
A wrong coverage mask or a dropped status fold shows up as a parity bit that fails the odd count over the registered data and status. It appears on the edge right after the character is loaded. A wrong forcing term shows in `out_stat[2]` on that same edge. If the second stage recomputed parity from the data instead of using the carried bit, it would show only when the carried bit disagrees with the byte. The sweep therefore also feeds inverted carried bits. A register that reloads without a valid read shows as a change in the outputs during idle cycles.

// File: rtl/rx_out_parity.sv
module rx_out_parity #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_code,
  input  logic              dec_en,
  input  logic              bist_en,
  input  logic [DATA_W-1:0] dec_data,
  output logic              dec_par,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_par,
  input  logic [STAT_W-1:0] rd_stat,
  input  logic              rd_framing,
  output logic [DATA_W-1:0] out_data,
  output logic [STAT_W-1:0] out_stat,
  output logic              out_par,
  output logic              out_par_oe
);

  localparam logic [STAT_W-1:0] LOW2_MASK = STAT_W'(3);
  localparam logic [STAT_W-1:0] ALL_MASK  = '1;

  logic              par_on, par_full;
  logic [STAT_W-1:0] stat_adj, stat_sel;
  logic              par_next, par_q, oe_q;

  assign par_on   = mode_code[1];
  assign par_full = mode_code == 2'b11;

  // first stage: byte parity carried through the FIFO
  assign dec_par = ~^dec_data;

  always_comb begin
    stat_adj = rd_stat;
    if (!dec_en && !bist_en && !rd_framing)
      stat_adj[STAT_W-1] = 1'b0;
  end

  assign stat_sel = par_full           ? ALL_MASK  :
                    (par_on && !dec_en) ? LOW2_MASK : '0;

  // second stage: fold late status into the carried bit
  assign par_next = rd_par ^ (^(stat_adj & stat_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_stat <= '0;
      par_q    <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      oe_q <= par_on;
      if (rd_valid) begin
        out_data <= rd_data;
        out_stat <= stat_adj;
        par_q    <= par_next;
      end
    end
  end

  assign out_par    = par_q & oe_q;
  assign out_par_oe = oe_q;

endmodule

module rx_out_parity_chk #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_code,
  input logic              dec_en,
  input logic              bist_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_par,
  input logic              rd_framing,
  input logic [DATA_W-1:0] out_data,
  input logic [STAT_W-1:0] out_stat,
  input logic              out_par,
  input logic              out_par_oe
);

  // R1
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_code[1] |=> (!out_par_oe && !out_par));

  // R3
  mid_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && mode_code == 2'b10 && dec_en && rd_par == ~^rd_data)
      |=> (^{out_data, out_par}) == 1'b1);

  // R4
  mid_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && mode_code == 2'b10 && !dec_en && rd_par == ~^rd_data)
      |=> (^{out_data, out_stat[1:0], out_par}) == 1'b1);

  // R5
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && mode_code == 2'b11 && rd_par == ~^rd_data)
      |=> (^{out_data, out_stat, out_par}) == 1'b1);

  // R6
  stat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !dec_en && !bist_en && !rd_framing) |=> !out_stat[STAT_W-1]);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> ($stable(out_data) && $stable(out_stat)));

endmodule

bind rx_out_parity rx_out_parity_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .dec_en(dec_en),
  .bist_en(bist_en), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_par(rd_par), .rd_framing(rd_framing), .out_data(out_data),
  .out_stat(out_stat), .out_par(out_par), .out_par_oe(out_par_oe)
);

// File: tb/test_rx_out_parity.sv
`timescale 1ns/1ps
module test_rx_out_parity;
  logic       clk = 0, rst_n = 0;
  logic [1:0] mode_code = 0;
  logic       dec_en = 0, bist_en = 0, rd_valid = 0, rd_par = 0, rd_framing = 0;
  logic [7:0] dec_data = 0, rd_data = 0;
  logic [2:0] rd_stat = 0;
  logic       dec_par, out_par, out_par_oe;
  logic [7:0] out_data;
  logic [2:0] out_stat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_out_parity i_rx_out_parity (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .dec_en(dec_en),
    .bist_en(bist_en), .dec_data(dec_data), .dec_par(dec_par),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par),
    .rd_stat(rd_stat), .rd_framing(rd_framing), .out_data(out_data),
    .out_stat(out_stat), .out_par(out_par), .out_par_oe(out_par_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stat(input logic [2:0] s, input logic d, b, f);
    logic [2:0] r = s;
    if (!d && !b && !f) r[2] = 1'b0;
    return r;
  endfunction

  function automatic logic exp_parity(input logic [1:0] m, input logic d,
                                      input logic [7:0] x, input logic [2:0] s);
    logic [2:0] mask;
    if (!m[1]) return 1'b0;
    mask = (m == 2'b11) ? 3'b111 : (!d ? 3'b011 : 3'b000);
    return ~^{x, s & mask};
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] es;
    logic ep;
    string rq;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", {out_data, out_stat, out_par, out_par_oe}, 0);
    rst_n = 1;

    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int x = 0; x < 256; x++) begin
          for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            mode_code = 2'(m); dec_en = d[0];
            dec_data = 8'(x); rd_data = 8'(x); rd_stat = 3'(s);
            bist_en = x[1] ^ s[0]; rd_framing = x[2] ^ s[1];
            // R7: every fourth vector carries an inverted byte parity
            rd_par = ~^rd_data ^ (x[1:0] == 2'b11);
            rd_valid = 1;
            #1;
            // R2 first stage
            chk("R2", dec_par, ~^dec_data);
            es = exp_stat(rd_stat, dec_en, bist_en, rd_framing);
            ep = exp_parity(mode_code, dec_en, rd_data, es);
            if (mode_code[1] && x[1:0] == 2'b11) ep = ~ep;
            rq = !mode_code[1] ? "R1" : (mode_code == 2'b11 ? "R5" : (dec_en ? "R3" : "R4"));
            if (x[1:0] == 2'b11 && mode_code[1]) rq = "R7";
            @(negedge clk);
            chk("R8", out_data, rd_data);
            chk("R6", out_stat, es);
            chk(rq, out_par, ep);
            chk("R1", out_par_oe, mode_code[1]);
          end
        end
      end
    end

    // R8 hold with rd_valid low
    @(negedge clk);
    mode_code = 2'b11; dec_en = 1; rd_data = 8'h5A; rd_stat = 3'b101;
    rd_par = ~^rd_data; rd_valid = 1; bist_en = 0; rd_framing = 0;
    @(negedge clk);
    rd_valid = 0; rd_data = 8'hC3; rd_stat = 3'b010; rd_par = 0;
    repeat (3) @(negedge clk);
    chk("R8", out_data, 8'h5A);
    chk("R8", out_stat, 3'b101);
    chk("R8", out_par, ~^{8'h5A, 3'b101});
    // R1 switching off while holding
    mode_code = 2'b01;
    @(negedge clk);
    chk("R1", {out_par_oe, out_par}, 0);
    chk("R8", out_data, 8'h5A);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule